// File: doc/BRIEF.md
# Ratio-Selectable System Clock Divider

This block turns a fast core-rate enable into three phase-aligned clock-enable strobes: one for the processor core, one for the high-speed system bus and one for the peripheral bus. The three run together at one of two ratio sets, 1:4:8 or 1:3:6. A separate divider turns a second enable source into a USB clock enable, either passing it through or halving it. All sources and outputs are single-cycle enable pulses in one clock domain. The frequency synthesiser that feeds the sources is outside the block.

A small divider-control word chooses the ratio set and the USB ratio. A ratio-set change written while the dividers are running waits for the next point where every counter sits at zero, so no bus strobe ever comes early. A bypass input feeds the core path from the raw external reference instead of the synthesised source. A core-gate input silences only the core strobe, and the bus strobes keep running.

Top module: `sysclk_ratio_div`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, every output is low. Reset selects the 1:4:8 set and the USB 1:1 ratio, and clears every divider counter.
- R2: With bypass_i low, core_en_o is high exactly one cycle after a cycle in which core_src_en_i was high and core_gate_i was low.
- R3: Under the 1:4:8 set (control bit 0 = 0), hbus_en_o fires on every 4th core tick and pbus_en_o on every 8th. Both fire on the first tick after reset. Each strobe lags its tick by one cycle.
- R4: Under the 1:3:6 set (control bit 0 = 1), hbus_en_o fires on every 3rd core tick and pbus_en_o on every 6th.
- R5: pbus_en_o is high only in cycles where hbus_en_o is also high.
- R6: A new ratio set takes effect only on a core tick where both the bus counter and the peripheral counter are zero. Until that tick, strobes keep the old spacing.
- R7: With control bit 2 = 0, usb_en_o is high exactly one cycle after each cycle with usb_src_en_i high.
- R8: With control bit 2 = 1, usb_en_o fires on every second usb_src_en_i pulse. The first pulse after the bit is set produces a strobe.
- R9: With bypass_i high, the core tick is ref_en_i instead of core_src_en_i. This applies to the core strobe and to both bus dividers.
- R10: core_gate_i high suppresses core_en_o. The bus dividers keep counting ticks and keep producing hbus_en_o and pbus_en_o.
- R11: Control bit 1 has no effect on any output.
- R12: div_wr_i high loads div_wdata_i into the control word at the clock edge. Bit 2 acts from the following cycle. Bit 0 acts at the next alignment tick, as R6 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| core_src_en_i | input | 1 | Synthesised core-rate enable pulse |
| ref_en_i | input | 1 | External reference enable pulse, used in bypass |
| usb_src_en_i | input | 1 | USB source enable pulse |
| bypass_i | input | 1 | Selects ref_en_i as the core tick |
| core_gate_i | input | 1 | Stops the core strobe only |
| div_wr_i | input | 1 | Control word write strobe |
| div_wdata_i | input | 3 | Control word: bit 0 ratio set, bit 2 USB divide-by-2 |
| core_en_o | output | 1 | Core clock enable strobe |
| hbus_en_o | output | 1 | High-speed bus clock enable strobe |
| pbus_en_o | output | 1 | Peripheral bus clock enable strobe |
| usb_en_o | output | 1 | USB clock enable strobe |

## Verification
A stuck or mis-wrapped bus counter changes the gap between hbus_en_o strobes within one bus period, at most four core ticks. A peripheral counter out of step shows as a pbus_en_o strobe without an hbus_en_o strobe, or as a missing one, within eight ticks. A ratio set that switches too early is visible in the first bus period after the write, because a gap comes out too short. A USB divider that is out of phase shows in the first strobe after the ratio bit changes.

// File: rtl/sysclk_ratio_pkg.sv
package sysclk_ratio_pkg;

  localparam int CTRL_W  = 3;
  localparam int SET_BIT = 0;
  localparam int USB_BIT = 2;

  typedef enum logic {
    SET_1_4_8 = 1'b0,
    SET_1_3_6 = 1'b1
  } ratio_set_e;

  // core ticks per high-speed bus strobe for each set
  localparam int HBUS_DIV_A = 4;
  localparam int HBUS_DIV_B = 3;
  // high-speed bus strobes per peripheral strobe, same in both sets
  localparam int PBUS_DIV   = 2;
  localparam int USB_DIV    = 2;

  localparam int HCNT_W = $clog2(HBUS_DIV_A > HBUS_DIV_B ? HBUS_DIV_A : HBUS_DIV_B);
  localparam int PCNT_W = (PBUS_DIV > 1) ? $clog2(PBUS_DIV) : 1;
  localparam int UCNT_W = (USB_DIV > 1) ? $clog2(USB_DIV) : 1;

  function automatic logic [HCNT_W-1:0] hbus_last(ratio_set_e s);
    return (s == SET_1_3_6) ? HCNT_W'(HBUS_DIV_B - 1) : HCNT_W'(HBUS_DIV_A - 1);
  endfunction

endpackage

// File: rtl/sysclk_div_ctrl.sv
module sysclk_div_ctrl
  import sysclk_ratio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              align_i,
  output ratio_set_e        act_set_o,
  output logic              usb_div2_o
);

  logic [CTRL_W-1:0] cfg_q;
  ratio_set_e        act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (wr_i) begin
      cfg_q <= wdata_i;
    end
  end

  // set change committed only at the common zero point
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= SET_1_4_8;
    end else if (align_i) begin
      act_q <= ratio_set_e'(cfg_q[SET_BIT]);
    end
  end

  assign act_set_o  = act_q;
  assign usb_div2_o = cfg_q[USB_BIT];

endmodule

// File: rtl/sysclk_bus_div.sv
module sysclk_bus_div
  import sysclk_ratio_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       core_gate_i,
  input  ratio_set_e act_set_i,
  output logic       align_o,
  output logic       core_en_o,
  output logic       hbus_en_o,
  output logic       pbus_en_o
);

  logic [HCNT_W-1:0] hcnt_q;
  logic [PCNT_W-1:0] pcnt_q;
  logic              h_hit, p_hit;
  logic              core_q, hbus_q, pbus_q;

  assign h_hit   = tick_i && (hcnt_q == '0);
  assign p_hit   = h_hit && (pcnt_q == '0);
  assign align_o = p_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
    end else if (tick_i) begin
      if (hcnt_q >= hbus_last(act_set_i)) hcnt_q <= '0;
      else                                hcnt_q <= hcnt_q + 1'b1;
    end
  end

  generate
    if (PBUS_DIV > 1) begin : g_pcnt
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pcnt_q <= '0;
        end else if (h_hit) begin
          if (pcnt_q == PCNT_W'(PBUS_DIV - 1)) pcnt_q <= '0;
          else                                 pcnt_q <= pcnt_q + 1'b1;
        end
      end
    end else begin : g_no_pcnt
      assign pcnt_q = '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_q <= 1'b0;
      hbus_q <= 1'b0;
      pbus_q <= 1'b0;
    end else begin
      core_q <= tick_i && !core_gate_i;
      hbus_q <= h_hit;
      pbus_q <= p_hit;
    end
  end

  assign core_en_o = core_q;
  assign hbus_en_o = hbus_q;
  assign pbus_en_o = pbus_q;

endmodule

// File: rtl/sysclk_usb_div.sv
module sysclk_usb_div
  import sysclk_ratio_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic div2_i,
  output logic usb_en_o
);

  logic [UCNT_W-1:0] ucnt_q;
  logic              hit;
  logic              usb_q;

  assign hit = src_i && (!div2_i || (ucnt_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ucnt_q <= '0;
    end else if (!div2_i) begin
      ucnt_q <= '0;
    end else if (src_i) begin
      if (ucnt_q == UCNT_W'(USB_DIV - 1)) ucnt_q <= '0;
      else                                ucnt_q <= ucnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) usb_q <= 1'b0;
    else         usb_q <= hit;
  end

  assign usb_en_o = usb_q;

endmodule

// File: rtl/sysclk_ratio_div.sv
module sysclk_ratio_div
  import sysclk_ratio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              core_src_en_i,
  input  logic              ref_en_i,
  input  logic              usb_src_en_i,
  input  logic              bypass_i,
  input  logic              core_gate_i,
  input  logic              div_wr_i,
  input  logic [CTRL_W-1:0] div_wdata_i,
  output logic              core_en_o,
  output logic              hbus_en_o,
  output logic              pbus_en_o,
  output logic              usb_en_o
);

  logic       tick;
  logic       align;
  logic       usb_div2;
  ratio_set_e act_set;

  assign tick = bypass_i ? ref_en_i : core_src_en_i;

  sysclk_div_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (div_wr_i),
    .wdata_i    (div_wdata_i),
    .align_i    (align),
    .act_set_o  (act_set),
    .usb_div2_o (usb_div2)
  );

  sysclk_bus_div u_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .core_gate_i (core_gate_i),
    .act_set_i   (act_set),
    .align_o     (align),
    .core_en_o   (core_en_o),
    .hbus_en_o   (hbus_en_o),
    .pbus_en_o   (pbus_en_o)
  );

  sysclk_usb_div u_usb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (usb_src_en_i),
    .div2_i   (usb_div2),
    .usb_en_o (usb_en_o)
  );

endmodule

// File: rtl/sysclk_ratio_div_chk.sv
module sysclk_ratio_div_chk
  import sysclk_ratio_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              core_src_en_i,
  input logic              ref_en_i,
  input logic              usb_src_en_i,
  input logic              bypass_i,
  input logic              core_gate_i,
  input logic              div_wr_i,
  input logic [CTRL_W-1:0] div_wdata_i,
  input logic              core_en_o,
  input logic              hbus_en_o,
  input logic              pbus_en_o,
  input logic              usb_en_o
);

  logic started_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) started_q <= 1'b0;
    else         started_q <= 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !started_q |-> !(core_en_o || hbus_en_o || pbus_en_o || usb_en_o));

  assert_core_from_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && core_en_o) |-> $past(bypass_i ? ref_en_i : core_src_en_i));

  assert_hbus_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hbus_en_o |=> !hbus_en_o);

  assert_pbus_in_hbus_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pbus_en_o |-> hbus_en_o);

  assert_usb_from_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && usb_en_o) |-> $past(usb_src_en_i));

  assert_core_gated_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && core_en_o) |-> !$past(core_gate_i));

endmodule

bind sysclk_ratio_div sysclk_ratio_div_chk u_chk (.*);

// File: tb/sysclk_ratio_div_test.sv
`timescale 1ns/1ps
module sysclk_ratio_div_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       core_src_en_i = 1'b0, ref_en_i = 1'b0, usb_src_en_i = 1'b0;
  logic       bypass_i = 1'b0, core_gate_i = 1'b0, div_wr_i = 1'b0;
  logic [2:0] div_wdata_i = '0;
  logic       core_en_o, hbus_en_o, pbus_en_o, usb_en_o;

  int total = 0, bad = 0;
  bit done = 0;
  int n_core, n_hbus, n_pbus, n_usb;

  // reference model state
  int   m_h = 0, m_p = 0, m_u = 0;
  bit   m_act = 0;
  bit [2:0] m_cfg = '0;
  bit   e_core = 0, e_hbus = 0, e_pbus = 0, e_usb = 0;

  always #2 clk_i = ~clk_i;

  sysclk_ratio_div uut (.*);

  function automatic int hlast(bit s);
    return s ? 2 : 3;
  endfunction

  task automatic chk(string req, string nm, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, nm, act, exp);
    end
  endtask

  task automatic model_step();
    bit t, hh, ph;
    t  = bypass_i ? ref_en_i : core_src_en_i;
    hh = t && (m_h == 0);
    ph = hh && (m_p == 0);
    e_core = t && !core_gate_i;
    e_hbus = hh;
    e_pbus = ph;
    e_usb  = usb_src_en_i && (!m_cfg[2] || m_u == 0);
    if (t) m_h = (m_h >= hlast(m_act)) ? 0 : m_h + 1;
    if (hh) m_p = (m_p == 1) ? 0 : 1;
    if (ph) m_act = m_cfg[0];
    if (!m_cfg[2]) m_u = 0;
    else if (usb_src_en_i) m_u = (m_u == 1) ? 0 : 1;
    if (div_wr_i) m_cfg = div_wdata_i;
  endtask

  // one cycle: inputs already set at negedge
  task automatic cycle();
    model_step();
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R2", "core_en", core_en_o, e_core);
    chk("R3", "hbus_en", hbus_en_o, e_hbus);
    chk("R5", "pbus_en", pbus_en_o, e_pbus);
    chk("R7", "usb_en",  usb_en_o,  e_usb);
    n_core += core_en_o; n_hbus += hbus_en_o; n_pbus += pbus_en_o; n_usb += usb_en_o;
  endtask

  task automatic clr();
    n_core = 0; n_hbus = 0; n_pbus = 0; n_usb = 0;
  endtask

  task automatic idle();
    core_src_en_i = 0; ref_en_i = 0; usb_src_en_i = 0; div_wr_i = 0;
  endtask

  task automatic wr(bit [2:0] v);
    idle();
    div_wr_i = 1; div_wdata_i = v;
    cycle();
    div_wr_i = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4.0 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_c10c));
    repeat (3) @(negedge clk_i);
    // R1: outputs quiet in reset
    chk("R1", "core_en", core_en_o, 0);
    chk("R1", "hbus_en", hbus_en_o, 0);
    chk("R1", "pbus_en", pbus_en_o, 0);
    chk("R1", "usb_en",  usb_en_o,  0);
    rst_ni = 1;
    cycle();

    // R3: default set 1:4:8, continuous ticks
    clr(); core_src_en_i = 1;
    repeat (96) cycle();
    chk("R3", "core count", n_core, 96);
    chk("R3", "hbus count", n_hbus, 24);
    chk("R3", "pbus count", n_pbus, 12);

    // R11: bit 1 alone changes nothing
    wr(3'b010);
    clr(); core_src_en_i = 1; usb_src_en_i = 1;
    repeat (48) cycle();
    chk("R11", "hbus count", n_hbus, 12);
    chk("R11", "pbus count", n_pbus, 6);
    chk("R11", "usb count",  n_usb,  48);

    // R4 / R12: switch to 1:3:6 at alignment
    wr(3'b001);
    clr(); core_src_en_i = 1;
    repeat (48) cycle();
    chk("R4", "hbus count", n_hbus, 16);
    chk("R4", "pbus count", n_pbus, 8);

    // R6: change mid-period, old spacing until alignment
    repeat (2) cycle();
    wr(3'b000);
    clr(); core_src_en_i = 1;
    repeat (12) cycle();
    chk("R6", "hbus count", n_hbus, 3);

    // R7 / R8: USB ratio
    wr(3'b000);
    clr(); usb_src_en_i = 1;
    repeat (20) cycle();
    chk("R7", "usb count", n_usb, 20);
    wr(3'b100);
    clr(); usb_src_en_i = 1;
    repeat (20) cycle();
    chk("R8", "usb count", n_usb, 10);
    chk("R12", "usb first strobe seen", n_usb > 0, 1);

    // R9: bypass selects reference
    idle(); bypass_i = 1; clr();
    for (int i = 0; i < 50; i++) begin
      core_src_en_i = 1;
      ref_en_i = (i % 5 == 0);
      cycle();
    end
    chk("R9", "core count", n_core, 10);
    bypass_i = 0;

    // R10: gate stops core only
    idle(); core_src_en_i = 1; core_gate_i = 1; clr();
    repeat (40) cycle();
    chk("R10", "core count", n_core, 0);
    chk("R10", "hbus count", n_hbus, 10);
    core_gate_i = 0;

    // random mix, per-cycle model compare
    for (int i = 0; i < 4000; i++) begin
      core_src_en_i = ($urandom % 4) != 0;
      ref_en_i      = ($urandom % 3) == 0;
      usb_src_en_i  = ($urandom % 2) == 0;
      bypass_i      = ($urandom % 16) == 0;
      core_gate_i   = ($urandom % 8) == 0;
      div_wr_i      = ($urandom % 40) == 0;
      div_wdata_i   = 3'($urandom);
      cycle();
    end
    idle();
    finish_run();
  end

endmodule